// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block turns a framebuffer description into a stream of burst read requests that a display pipeline uses to fetch pixels one line after another. Software sets a start address, the number of bytes that carry pixels in each line, the distance in bytes from one line start to the next, and the number of lines less one. A pulse on `frame_start` captures those settings and begins a new frame at the start address.

Inside a line the block steps through the bytes in bursts of up to 16 beats of `BEAT_BYTES` bytes. The last burst of a line is trimmed to the beats that still hold line data. When a line is done, the next line start is the previous one plus the pitch. The pitch may be larger than the line length, so padded lines are supported. Requests use a valid/ready handshake. A completion pulse per finished read returns a credit, and the number of requests in flight never goes above a programmable limit. A frame whose line count is past the supported maximum, or whose line length is zero, is refused and flagged.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `req_valid` and `frame_err` are low until a frame is started.
- R2: `frame_start` captures base, line length, pitch and line count. The first request of the frame is at the captured base. Changes to these inputs during a frame take effect only at the next `frame_start`.
- R3: Line i (0-based) starts at base + i*pitch. The requests within a line sit at byte offsets 0, 128, 256 and so on from the line start (16 beats of 8 bytes with default parameters).
- R4: `req_beats_m1` holds the beat count minus one. Every request is 15 (16 beats) except the last of a line, which is ceil(remaining_bytes/8) - 1.
- R5: After exactly `cfg_lines_m1`+1 lines have been requested, no further request is raised until the next `frame_start`.
- R6: A request that is not accepted stays raised with unchanged address and beat count, unless `frame_start` arrives or the limit changes.
- R7: The in-flight count rises by one per accepted request (`req_valid` and `req_ready` high) and falls by one per `rd_done` pulse. No request is raised while the count equals `cfg_max_out`.
- R8: A `frame_start` in the middle of a frame drops the rest of that frame. The next request is at the newly captured base.
- R9: If `cfg_lines_m1` is 4096 or more, or `cfg_line_bytes` is 0, when `frame_start` occurs, `frame_err` goes high and no request is raised in that frame. The next accepted `frame_start` clears `frame_err`.
- R10: The largest line count, `cfg_lines_m1` = 4095, is accepted and all 4096 lines are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_base | input | 32 | Framebuffer start address |
| cfg_line_bytes | input | 16 | Bytes of pixel data per line |
| cfg_pitch | input | 16 | Byte distance between line starts |
| cfg_lines_m1 | input | 13 | Number of lines minus one |
| cfg_max_out | input | 4 | Limit on requests in flight |
| frame_start | input | 1 | One-cycle pulse that starts a frame |
| req_valid | output | 1 | Read request present |
| req_ready | input | 1 | Request accepted this cycle when high with `req_valid` |
| req_addr | output | 32 | Byte address of the burst |
| req_beats_m1 | output | 4 | Burst length in beats minus one |
| rd_done | input | 1 | One pulse per completed read burst |
| frame_err | output | 1 | Last started frame was refused |

## Verification
Each frame shape is run against a scoreboard of the addresses and burst lengths it should produce. An unpadded frame whose line length is a whole number of bursts shows the pitch step. A padded frame with a partial final burst, and a line length that is not a multiple of the beat size, show the trimming of the last burst. A one-byte line gives the smallest burst. The acceptance side is tested three ways: always ready, ready on alternate cycles, and an irregular pattern. This separates held requests from advancing ones. A limit of one with slow completions makes the in-flight cap the thing that paces the requests. Further runs cover a mid-frame change of settings, a restart in mid-frame, both refused settings, and the full 4096-line frame.

// File: rtl/fb_scan_pkg.sv
package fb_scan_pkg;
  // Walker state: idle between frames, run while lines remain to request.
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/fb_scan_cfg_latch.sv
// Holds the per-frame geometry captured on frame_start and judges it.
module fb_scan_cfg_latch #(
  parameter int unsigned LW        = 16,
  parameter int unsigned PW        = 16,
  parameter int unsigned CW        = 13,
  parameter int unsigned MAX_LINES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [LW-1:0] cfg_line_bytes,
  input  logic [PW-1:0] cfg_pitch,
  input  logic [CW-1:0] cfg_lines_m1,
  output logic [LW-1:0] sh_line_bytes,
  output logic [PW-1:0] sh_pitch,
  output logic [CW-1:0] sh_lines_m1,
  output logic          cfg_ok,
  output logic          frame_err
);
  logic [LW-1:0] len_n;
  logic [PW-1:0] pitch_n;
  logic [CW-1:0] lines_n;
  logic          err_n;

  // Geometry is usable when the line count is in range and lines carry data.
  always_comb begin
    cfg_ok = (32'(cfg_lines_m1) < MAX_LINES) && (cfg_line_bytes != '0);
  end

  always_comb begin
    len_n   = cfg_line_bytes;
    pitch_n = cfg_pitch;
    lines_n = cfg_lines_m1;
    err_n   = !cfg_ok;
  end

  // Clock enable: the shadow copy changes only at a frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_line_bytes <= '0;
      sh_pitch      <= '0;
      sh_lines_m1   <= '0;
      frame_err     <= 1'b0;
    end else if (frame_start) begin
      sh_line_bytes <= len_n;
      sh_pitch      <= pitch_n;
      sh_lines_m1   <= lines_n;
      frame_err     <= err_n;
    end
  end
endmodule

// File: rtl/fb_line_walker.sv
// Walks line starts by the pitch and byte offsets by whole bursts.
module fb_line_walker
  import fb_scan_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned LW         = 16,
  parameter int unsigned PW         = 16,
  parameter int unsigned CW         = 13,
  parameter int unsigned BEAT_BYTES = 8,
  parameter int unsigned MAX_BEATS  = 16,
  parameter int unsigned BW         = $clog2(MAX_BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          start_ok,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] sh_line_bytes,
  input  logic [PW-1:0] sh_pitch,
  input  logic [CW-1:0] sh_lines_m1,
  input  logic          issue,
  output logic          active,
  output logic [AW-1:0] req_addr,
  output logic [BW-1:0] req_beats_m1
);
  localparam int unsigned BSH   = $clog2(BEAT_BYTES);
  localparam int unsigned BURST = MAX_BEATS * BEAT_BYTES;

  walk_state_e   st_q, st_n;
  logic [AW-1:0] line_q, line_n;
  logic [LW-1:0] offs_q, offs_n;
  logic [CW-1:0] idx_q, idx_n;
  logic [LW-1:0] rem;
  logic [LW:0]   rem_up;
  logic          last;
  logic          upd;

  // Remaining bytes of the line decide whether this burst closes it.
  always_comb begin
    rem    = sh_line_bytes - offs_q;
    last   = (rem <= LW'(BURST));
    rem_up = {1'b0, rem} + (LW+1)'(BEAT_BYTES - 1);
    req_beats_m1 = last ? BW'((rem_up >> BSH) - 1'b1) : BW'(MAX_BEATS - 1);
    req_addr     = line_q + AW'(offs_q);
    active       = (st_q == WALK_RUN);
  end

  always_comb begin
    st_n   = st_q;
    line_n = line_q;
    offs_n = offs_q;
    idx_n  = idx_q;
    upd    = 1'b0;
    if (frame_start) begin
      upd    = 1'b1;
      st_n   = start_ok ? WALK_RUN : WALK_IDLE;
      line_n = cfg_base;
      offs_n = '0;
      idx_n  = '0;
    end else if (active && issue) begin
      upd = 1'b1;
      if (last) begin
        offs_n = '0;
        line_n = line_q + AW'(sh_pitch);
        idx_n  = idx_q + 1'b1;
        if (idx_q == sh_lines_m1) st_n = WALK_IDLE;
      end else begin
        offs_n = offs_q + LW'(BURST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WALK_IDLE;
      line_q <= '0;
      offs_q <= '0;
      idx_q  <= '0;
    end else if (upd) begin
      st_q   <= st_n;
      line_q <= line_n;
      offs_q <= offs_n;
      idx_q  <= idx_n;
    end
  end
endmodule

// File: rtl/fb_credit_ctr.sv
// Counts read bursts in flight against a programmable ceiling.
module fb_credit_ctr #(
  parameter int unsigned MAX_OUT = 15,
  parameter int unsigned CNTW    = $clog2(MAX_OUT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            give,
  input  logic [CNTW-1:0] limit,
  output logic [CNTW-1:0] count,
  output logic            room
);
  logic [CNTW-1:0] cnt_n;
  logic            upd;

  always_comb begin
    room  = (count < limit);
    cnt_n = count;
    upd   = 1'b0;
    if (take && !give) begin
      cnt_n = count + 1'b1;
      upd   = 1'b1;
    end else if (give && !take && (count != '0)) begin
      cnt_n = count - 1'b1;
      upd   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (upd) count <= cnt_n;
  end
endmodule

// File: rtl/fb_scan_addr_gen.sv
// Top: frame geometry capture, line walker and in-flight credit control.
module fb_scan_addr_gen #(
  parameter int unsigned AW         = 32,
  parameter int unsigned LINE_W     = 16,
  parameter int unsigned PITCH_W    = 16,
  parameter int unsigned LCNT_W     = 13,
  parameter int unsigned MAX_LINES  = 4096,
  parameter int unsigned BEAT_BYTES = 8,
  parameter int unsigned MAX_BEATS  = 16,
  parameter int unsigned MAX_OUT    = 15,
  localparam int unsigned OUT_W     = $clog2(MAX_OUT + 1),
  localparam int unsigned BEATS_W   = $clog2(MAX_BEATS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cfg_base,
  input  logic [LINE_W-1:0]  cfg_line_bytes,
  input  logic [PITCH_W-1:0] cfg_pitch,
  input  logic [LCNT_W-1:0]  cfg_lines_m1,
  input  logic [OUT_W-1:0]   cfg_max_out,
  input  logic               frame_start,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [AW-1:0]      req_addr,
  output logic [BEATS_W-1:0] req_beats_m1,
  input  logic               rd_done,
  output logic               frame_err
);
  logic [LINE_W-1:0]  sh_line_bytes;
  logic [PITCH_W-1:0] sh_pitch;
  logic [LCNT_W-1:0]  sh_lines_m1;
  logic               cfg_ok;
  logic               walk_active;
  logic               room;
  logic               issue;
  logic [OUT_W-1:0]   out_cnt;

  always_comb begin
    req_valid = walk_active && room;
    issue     = req_valid && req_ready;
  end

  fb_scan_cfg_latch #(
    .LW(LINE_W), .PW(PITCH_W), .CW(LCNT_W), .MAX_LINES(MAX_LINES)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch), .cfg_lines_m1(cfg_lines_m1),
    .sh_line_bytes(sh_line_bytes), .sh_pitch(sh_pitch), .sh_lines_m1(sh_lines_m1),
    .cfg_ok(cfg_ok), .frame_err(frame_err)
  );

  fb_line_walker #(
    .AW(AW), .LW(LINE_W), .PW(PITCH_W), .CW(LCNT_W),
    .BEAT_BYTES(BEAT_BYTES), .MAX_BEATS(MAX_BEATS), .BW(BEATS_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .start_ok(cfg_ok),
    .cfg_base(cfg_base), .sh_line_bytes(sh_line_bytes), .sh_pitch(sh_pitch),
    .sh_lines_m1(sh_lines_m1), .issue(issue), .active(walk_active),
    .req_addr(req_addr), .req_beats_m1(req_beats_m1)
  );

  fb_credit_ctr #(
    .MAX_OUT(MAX_OUT), .CNTW(OUT_W)
  ) u_credit (
    .clk(clk), .rst_n(rst_n), .take(issue), .give(rd_done),
    .limit(cfg_max_out), .count(out_cnt), .room(room)
  );
endmodule

// File: rtl/fb_scan_addr_gen_chk.sv
module fb_scan_addr_gen_chk #(
  parameter int unsigned AW      = 32,
  parameter int unsigned OUT_W   = 4,
  parameter int unsigned BEATS_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic [AW-1:0]      cfg_base,
  input logic [OUT_W-1:0]   cfg_max_out,
  input logic               req_valid,
  input logic               req_ready,
  input logic [AW-1:0]      req_addr,
  input logic [BEATS_W-1:0] req_beats_m1,
  input logic               frame_err,
  input logic [OUT_W-1:0]   out_cnt
);
  // R7
  credit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt > $past(out_cnt)) |-> $past(req_valid && req_ready));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_ready) && $stable(cfg_max_out)) |-> (out_cnt <= cfg_max_out));

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_start) |=>
      ($stable(req_addr) && $stable(req_beats_m1) && (req_valid || !$stable(cfg_max_out))));

  // R2
  base_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!req_valid || (req_addr == $past(cfg_base))));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !req_valid);
endmodule

bind fb_scan_addr_gen fb_scan_addr_gen_chk #(
  .AW(AW), .OUT_W(OUT_W), .BEATS_W(BEATS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_base(cfg_base),
  .cfg_max_out(cfg_max_out), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_beats_m1(req_beats_m1), .frame_err(frame_err),
  .out_cnt(out_cnt)
);

// File: tb/fb_scan_addr_gen_test.sv
module fb_scan_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] cfg_base;
  logic [15:0] cfg_line_bytes;
  logic [15:0] cfg_pitch;
  logic [12:0] cfg_lines_m1;
  logic [3:0]  cfg_max_out;
  logic        frame_start;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [3:0]  req_beats_m1;
  logic        rd_done;
  logic        frame_err;

  typedef struct packed { logic [31:0] addr; logic [3:0] bm1; } exp_t;
  exp_t exp_q[$];

  int n_cmp;
  int n_bad;
  int acc_cnt;
  int done_cnt;
  int cyc;
  int ready_mode;
  bit slow_done;

  fb_scan_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes),
    .cfg_pitch(cfg_pitch), .cfg_lines_m1(cfg_lines_m1), .cfg_max_out(cfg_max_out),
    .frame_start(frame_start), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats_m1(req_beats_m1), .rd_done(rd_done),
    .frame_err(frame_err)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Driver side of the scoreboard: expected bursts of one frame.
  task automatic push_frame(input logic [31:0] base, input int len, input int pitch, input int lines_m1);
    if (lines_m1 >= 4096 || len == 0) return;
    for (int ln = 0; ln <= lines_m1; ln++) begin
      for (int off = 0; off < len; off += 128) begin
        exp_t e;
        int rem;
        int beats;
        rem   = len - off;
        beats = (rem >= 128) ? 16 : (rem + 7) / 8;
        e.addr = base + 32'(ln) * 32'(pitch) + 32'(off);
        e.bm1  = 4'(beats - 1);
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic start_frame(input logic [31:0] base, input int len, input int pitch,
                             input int lines_m1, input int limit);
    @(negedge clk);
    cfg_base       = base;
    cfg_line_bytes = 16'(len);
    cfg_pitch      = 16'(pitch);
    cfg_lines_m1   = 13'(lines_m1);
    cfg_max_out    = 4'(limit);
    frame_start    = 1'b1;
    #3;
    exp_q.delete();
    push_frame(base, len, pitch, lines_m1);
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic first_req_is(input logic [31:0] base, input string tag);
    #3;
    while (!req_valid) begin
      @(negedge clk);
      #3;
    end
    chk(req_addr == base, tag, req_addr, base);
  endtask

  task automatic finish_frame();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    #3;
    chk(!req_valid, "R5 no request after last line", req_valid, 0);
  endtask

  task automatic run_frame(input logic [31:0] base, input int len, input int pitch,
                           input int lines_m1, input int limit);
    start_frame(base, len, pitch, lines_m1, limit);
    finish_frame();
  endtask

  // Acceptance pattern on the request side.
  initial begin
    req_ready = 1'b0;
    forever begin
      @(negedge clk);
      case (ready_mode)
        0:       req_ready = 1'b1;
        1:       req_ready = cyc[0];
        default: req_ready = (cyc % 3) != 0;
      endcase
    end
  end

  // Completion model: one rd_done per accepted burst, optionally slowed.
  initial begin
    rd_done = 1'b0;
    forever begin
      @(negedge clk);
      rd_done = 1'b0;
      if (rst_n && acc_cnt > done_cnt && (!slow_done || cyc[1:0] == 2'b00)) begin
        rd_done  = 1'b1;
        done_cnt = done_cnt + 1;
      end
    end
  end

  // Monitor side of the scoreboard.
  initial begin
    bit          hold_pend;
    logic [31:0] hold_addr;
    hold_pend = 1'b0;
    hold_addr = '0;
    forever begin
      int   inflight;
      exp_t e;
      @(negedge clk);
      #2;
      if (hold_pend)
        chk(req_valid && req_addr == hold_addr, "R6 held request", req_addr, hold_addr);
      hold_pend = rst_n && req_valid && !req_ready && !frame_start;
      hold_addr = req_addr;
      if (rst_n && req_valid) begin
        inflight = acc_cnt - (done_cnt - int'(rd_done));
        chk(inflight < int'(cfg_max_out), "R7 request only below limit", inflight, cfg_max_out);
        if (req_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected request", req_addr, 0);
          end else begin
            e = exp_q.pop_front();
            chk(req_addr == e.addr, "R3 request address", req_addr, e.addr);
            chk(req_beats_m1 == e.bm1, "R4 burst beats minus one", req_beats_m1, e.bm1);
          end
          acc_cnt = acc_cnt + 1;
        end
      end
    end
  end

  initial begin
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; acc_cnt = 0; done_cnt = 0;
    ready_mode = 0; slow_done = 1'b0;
    rst_n = 1'b0; frame_start = 1'b0;
    cfg_base = '0; cfg_line_bytes = '0; cfg_pitch = '0; cfg_lines_m1 = '0; cfg_max_out = '0;
    repeat (2) @(negedge clk);
    #3;
    chk(!req_valid && !frame_err, "R1 outputs in reset", {req_valid, frame_err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    chk(!req_valid && !frame_err, "R1 outputs after reset", {req_valid, frame_err}, 0);

    // Unpadded frame, whole bursts per line.
    start_frame(32'h0000_1000, 256, 256, 2, 4);
    first_req_is(32'h0000_1000, "R2 first request at base");
    finish_frame();

    // Padded lines with a trimmed last burst, alternate ready.
    ready_mode = 1;
    run_frame(32'h0002_0010, 200, 512, 3, 4);

    // Length not a beat multiple, limit of one, slow completions.
    ready_mode = 2; slow_done = 1'b1;
    run_frame(32'h0003_0000, 100, 100, 4, 1);
    run_frame(32'h0003_8000, 1, 64, 1, 2);

    // R2: settings changed mid-frame are held off until the next frame.
    start_frame(32'h0004_0000, 384, 512, 5, 2);
    repeat (6) @(negedge clk);
    cfg_base = 32'h0009_0000; cfg_line_bytes = 16'd64; cfg_pitch = 16'd64; cfg_lines_m1 = 13'd0;
    finish_frame();
    start_frame(32'h0009_0000, 64, 64, 0, 2);
    first_req_is(32'h0009_0000, "R2 new base used next frame");
    finish_frame();

    // R8: restart in the middle of a frame.
    start_frame(32'h0000_5000, 512, 512, 7, 2);
    repeat (10) @(negedge clk);
    start_frame(32'h6000_0000, 128, 256, 1, 2);
    first_req_is(32'h6000_0000, "R8 restart at new base");
    finish_frame();

    // R9: refused settings.
    ready_mode = 0; slow_done = 1'b0;
    start_frame(32'h0007_0000, 64, 64, 4096, 4);
    repeat (20) @(negedge clk);
    #3;
    chk(frame_err && !req_valid, "R9 line count too large refused", {frame_err, req_valid}, 2);
    start_frame(32'h0007_0000, 0, 64, 3, 4);
    repeat (20) @(negedge clk);
    #3;
    chk(frame_err && !req_valid, "R9 zero line length refused", {frame_err, req_valid}, 2);
    start_frame(32'h0007_0000, 64, 64, 1, 4);
    #3;
    chk(!frame_err, "R9 error cleared by good frame", frame_err, 0);
    finish_frame();

    // R10: largest line count.
    start_frame(32'h0010_0000, 8, 8, 4095, 15);
    finish_frame();
    chk(acc_cnt == done_cnt, "R10 all bursts completed", acc_cnt, done_cnt);

    summary();
    $finish;
  end
endmodule